// File: doc/BRIEF.md
# Stereo Serial Audio Master Transmitter

This block is the output stage of a stereo converter that owns the audio bus clocks. It derives the bit clock and the word-select clock from a single core clock and shifts out one 24-bit two's-complement word per channel, MSB first, in a 64-bit-clock frame. Two framings are available: left-justified, and an I2S-style framing in which data lags the word-select edge by one bit clock.

Three speed modes set the frame rate. A pre-divide option halves every derived rate, as if the master clock were divided by two before any other division. The core clock `clk` runs at twice the nominal master-clock frequency. This lets every output, including a bit clock as fast as the master clock, come straight from a flip-flop: one master-clock period is 2 `clk` cycles, or 4 with the pre-divide on.

Upstream logic presents left and right words with a one-cycle strobe. Each frame takes its words from a holding stage loaded when the frame begins. For a programmable number of frames after reset, serial data is forced to zero while the reference settles.

Top module: `audio_tx_master`

## Requirements
- R1: The frame (LRCK) period is 512, 256 or 128 `clk` cycles for `speed_i` = 00, 01 and 10 when `half_i` = 0. Each of these periods doubles when `half_i` = 1.
- R2: Each frame holds exactly 64 SCLK periods. Within each bit, SCLK is low for the first half and high for the second, so it rises in mid-bit and falls at every bit boundary.
- R3: `lrck_o` and `sdata_o` change only in a cycle where `sclk_o` is low after the change, that is, together with a falling SCLK edge or while SCLK is idle.
- R4: With `fmt_i` = 0 (left-justified), `lrck_o` = 1 during the first 32 bits (left word) and 0 during the last 32 (right word). Bit 0 of each half carries word bit 23, and bits 24 to 31 of each half are 0.
- R5: With `fmt_i` = 1 (I2S framing), `lrck_o` = 0 during the left half and 1 during the right half. Bit 0 of each half is 0, bits 1 to 24 carry word bits 23 down to 0, and bits 25 to 31 are 0.
- R6: While `speed_i` = 11, `sclk_o`, `lrck_o` and `sdata_o` are held at 0 from the next edge on, so no frame is produced.
- R7: Serial data is 0 for the first MUTE_FRAMES frames after reset. It carries sample data from frame number MUTE_FRAMES on (counting from 0).
- R8: A strobe on `valid_i` stores both words in a pending stage. The pending words move to the shifting stage only on the edge that starts a frame. A strobe in mid-frame leaves the current frame unchanged, and a strobe on the frame-start edge itself is sent one frame later.
- R9: While `rst_n` is low, all three outputs are 0. The first frame begins on the first clock edge after release.
- R10: A change of `speed_i`, `half_i` or `fmt_i` to a valid setting starts a new frame on the next edge: SCLK low and LRCK at the left-channel level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_i | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 reserved |
| half_i | input | 1 | Master-clock pre-divide by two |
| fmt_i | input | 1 | 0 left-justified, 1 I2S framing |
| left_i | input | W | Left-channel word, two's complement |
| right_i | input | W | Right-channel word, two's complement |
| valid_i | input | 1 | One-cycle strobe that stores both words |
| sclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Word-select clock |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The word strobe and the frame-start transfer can land on the same clock edge. When they do, the pending stage takes the new word while the shifting stage takes the old one. The bench provokes this by counting one full frame of core cycles from an observed left-channel edge and raising the strobe exactly on the next frame-start edge. It then decodes that frame and the one after it, and expects the older word first and the newer word second. A strobe placed in mid-frame is judged the same way: the frame in flight must still carry the earlier word.

// File: rtl/audio_tx_master.sv
module audio_tx_master #(
  parameter int W           = 24,
  parameter int MUTE_FRAMES = 2500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   speed_i,
  input  logic         half_i,
  input  logic         fmt_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  input  logic         valid_i,
  output logic         sclk_o,
  output logic         lrck_o,
  output logic         sdata_o
);
  localparam int CW = 10;
  localparam int MW = $clog2(MUTE_FRAMES + 1);
  localparam logic [MW-1:0] MUTE_END = MW'(MUTE_FRAMES);

  logic [CW-1:0] cnt, cnt_nx, mask;
  logic [3:0]    k, s;
  logic [3:0]    cfg_q;
  logic [5:0]    bpos;
  logic [4:0]    slot, sel;
  logic [W-1:0]  pend_l, pend_r, hold_l, hold_r, hold_l_nx, hold_r_nx, word, word_sh;
  logic [MW-1:0] mcnt;
  logic          rsv, cfg_chg, fstart, hsel, sclk_n, lrck_n, live, live_n, bit_n;

  assign rsv     = speed_i == 2'b11;
  assign cfg_chg = {speed_i, half_i, fmt_i} != cfg_q;
  assign k       = (speed_i == 2'b00 ? 4'd9 : speed_i == 2'b01 ? 4'd8 : 4'd7) + {3'd0, half_i};
  assign s       = k - 4'd6;
  assign mask    = ~({CW{1'b1}} << k);
  assign cnt_nx  = cfg_chg ? '0 : (cnt + 1'b1) & mask;
  assign bpos    = 6'(cnt_nx >> s);
  assign sclk_n  = cnt_nx[s - 4'd1];
  assign hsel    = bpos[5];
  assign slot    = bpos[4:0];
  assign sel     = fmt_i ? slot - 5'd1 : slot;
  assign fstart  = !rsv && cnt_nx == '0;

  assign hold_l_nx = fstart ? pend_l : hold_l;
  assign hold_r_nx = fstart ? pend_r : hold_r;
  assign word      = hsel ? hold_r_nx : hold_l_nx;
  assign word_sh   = word << sel;
  assign live_n    = live | (fstart && mcnt == MUTE_END);
  assign bit_n     = live_n & word_sh[W-1];
  assign lrck_n    = fmt_i ? hsel : ~hsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '1;
      cfg_q   <= '0;
      pend_l  <= '0;
      pend_r  <= '0;
      hold_l  <= '0;
      hold_r  <= '0;
      mcnt    <= '0;
      live    <= 1'b0;
      sclk_o  <= 1'b0;
      lrck_o  <= 1'b0;
      sdata_o <= 1'b0;
    end else begin
      cfg_q <= {speed_i, half_i, fmt_i};
      if (valid_i) begin
        pend_l <= left_i;
        pend_r <= right_i;
      end
      if (rsv) begin
        cnt     <= '1;
        sclk_o  <= 1'b0;
        lrck_o  <= 1'b0;
        sdata_o <= 1'b0;
      end else begin
        cnt     <= cnt_nx;
        sclk_o  <= sclk_n;
        lrck_o  <= lrck_n;
        sdata_o <= bit_n;
        live    <= live_n;
        hold_l  <= hold_l_nx;
        hold_r  <= hold_r_nx;
        if (fstart && mcnt != MUTE_END) mcnt <= mcnt + 1'b1;
      end
    end
  end

  // R6
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv |=> (!sclk_o && !lrck_o && !sdata_o));

  // R7
  mute_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt < MUTE_END) |=> !sdata_o);

  // R3
  edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lrck_o != $past(lrck_o)) || (sdata_o != $past(sdata_o))) |-> !sclk_o);

  // R5
  i2s_lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fmt_i) && $fell(lrck_o)) |-> !sdata_o);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && !rsv) |=> (!sclk_o && (lrck_o == !$past(fmt_i))));
endmodule

// File: tb/sim_audio_tx_master.sv
module sim_audio_tx_master;
  localparam int W = 24;
  localparam int MUTE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] speed = 2'b00;
  logic half = 1'b0, fmt = 1'b0, stb = 1'b0;
  logic [W-1:0] l_in = '0, r_in = '0;
  logic sclk, lrck, sdata;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  audio_tx_master #(.W(W), .MUTE_FRAMES(MUTE)) u0 (
    .clk(clk), .rst_n(rst_n), .speed_i(speed), .half_i(half), .fmt_i(fmt),
    .left_i(l_in), .right_i(r_in), .valid_i(stb),
    .sclk_o(sclk), .lrck_o(lrck), .sdata_o(sdata));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk); l_in = l; r_in = r; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic wait_left();
    logic lft;
    lft = !fmt;
    do @(negedge clk); while (lrck == lft);
    do @(negedge clk); while (lrck != lft);
  endtask

  task automatic grab_now(output logic [W-1:0] lw, output logic [W-1:0] rw,
                          output int pad_bad, output int lr_bad, output int edge_bad);
    logic ps, pl, pd;
    lw = '0; rw = '0; pad_bad = 0; lr_bad = 0; edge_bad = 0;
    ps = sclk; pl = lrck; pd = sdata;
    for (int i = 0; i < 64; i++) begin
      bit got;
      int j, b;
      got = 1'b0;
      while (!got) begin
        @(negedge clk);
        if ((lrck !== pl || sdata !== pd) && sclk) edge_bad++;
        if (!ps && sclk) got = 1'b1;
        ps = sclk; pl = lrck; pd = sdata;
      end
      j = i % 32;
      b = fmt ? j - 1 : j;
      if (lrck !== ((i < 32) ? !fmt : fmt)) lr_bad++;
      if (b >= 0 && b < W) begin
        if (i < 32) lw[W-1-b] = sdata; else rw[W-1-b] = sdata;
      end else if (sdata !== 1'b0) pad_bad++;
    end
  endtask

  task automatic measure(output int psclk, output int plr);
    logic lft, ps, pl;
    int c, t1, t2;
    lft = !fmt;
    wait_left();
    c = 0; t1 = -1; t2 = -1; ps = sclk; pl = lrck;
    do begin
      @(negedge clk); c++;
      if (!ps && sclk) begin
        if (t1 < 0) t1 = c; else if (t2 < 0) t2 = c;
      end
      ps = sclk;
      if (lrck == lft && pl != lft) break;
      pl = lrck;
    end while (1);
    psclk = t2 - t1; plr = c;
  endtask

  task automatic frame_ok(input string tag, input logic [W-1:0] el, input logic [W-1:0] er, input bit do_wait);
    logic [W-1:0] lw, rw;
    int pb, lb, eb;
    if (do_wait) wait_left();
    grab_now(lw, rw, pb, lb, eb);
    chk(lw == el, {tag, " left word"}, 32'(lw), 32'(el));
    chk(rw == er, {tag, " right word"}, 32'(rw), 32'(er));
    chk(pb == 0 && lb == 0, {tag, " pad/lrck"}, 32'(pb + lb), 0);
    chk(eb == 0, "R3 change away from SCLK fall", 32'(eb), 0);
  endtask

  task automatic rates(input string tag, input int ep, input int ef);
    int p, f;
    measure(p, f);
    chk(p == ep, {tag, " R2 sclk period"}, 32'(p), 32'(ep));
    chk(f == ef, {tag, " R1 frame period"}, 32'(f), 32'(ef));
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(!sclk && !lrck && !sdata, "R9 outputs in reset", {29'd0, sclk, lrck, sdata}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lrck && !sclk, "R9 first frame after release", {30'd0, lrck, sclk}, 2);
  endtask

  task automatic t_mute();
    put(24'h800001, 24'h7FFFFE);
    frame_ok("R7 muted frame 1", '0, '0, 1'b1);
    frame_ok("R7 muted frame 2", '0, '0, 1'b1);
    frame_ok("R7 R4 first live frame", 24'h800001, 24'h7FFFFE, 1'b1);
  endtask

  task automatic t_lj_single();
    rates("LJ single", 8, 512);
    put(24'hA5C3E1, 24'h5A3C1E);
    frame_ok("R4 LJ single", 24'hA5C3E1, 24'h5A3C1E, 1'b1);
  endtask

  task automatic t_i2s_double_div();
    @(negedge clk); fmt = 1'b1; speed = 2'b01; half = 1'b1;
    rates("I2S double div", 8, 512);
    put(24'hFFFFFF, 24'h000001);
    frame_ok("R5 I2S double div", 24'hFFFFFF, 24'h000001, 1'b1);
  endtask

  task automatic t_quad();
    @(negedge clk); fmt = 1'b0; speed = 2'b10; half = 1'b0;
    rates("quad", 2, 128);
    put(24'h123456, 24'hFEDCBA);
    frame_ok("R4 quad", 24'h123456, 24'hFEDCBA, 1'b1);
    @(negedge clk); half = 1'b1;
    rates("quad div", 4, 256);
    @(negedge clk); fmt = 1'b1; half = 1'b0;
    frame_ok("R5 I2S quad", 24'h123456, 24'hFEDCBA, 1'b1);
  endtask

  task automatic t_reserved();
    int bad;
    @(negedge clk); speed = 2'b11;
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (sclk || lrck || sdata) bad++;
    end
    chk(bad == 0, "R6 reserved mode quiet", 32'(bad), 0);
    fmt = 1'b0; speed = 2'b00;
    @(negedge clk);
    chk(lrck && !sclk, "R6 R10 frame on leaving reserved", {30'd0, lrck, sclk}, 2);
  endtask

  task automatic t_restart();
    wait_left();
    do @(negedge clk); while (lrck);
    repeat (13) @(negedge clk);
    half = 1'b1;
    @(negedge clk);
    chk(lrck && !sclk, "R10 restart on pre-divide change", {30'd0, lrck, sclk}, 2);
    rates("single div", 16, 1024);
  endtask

  task automatic t_capture();
    @(negedge clk); speed = 2'b10; half = 1'b0; fmt = 1'b0;
    put(24'h0F0F0F, 24'hF0F0F0);
    wait_left();
    fork
      frame_ok("R8 mid-frame strobe keeps word", 24'h0F0F0F, 24'hF0F0F0, 1'b0);
      begin repeat (40) @(negedge clk); put(24'h333333, 24'hCCCCCC); end
    join
    frame_ok("R8 mid-frame strobe next frame", 24'h333333, 24'hCCCCCC, 1'b1);
    wait_left();
    repeat (127) @(negedge clk);
    l_in = 24'h654321; r_in = 24'h9ABCDE; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    frame_ok("R8 strobe on frame edge old word", 24'h333333, 24'hCCCCCC, 1'b0);
    frame_ok("R8 strobe on frame edge new word", 24'h654321, 24'h9ABCDE, 1'b1);
  endtask

  initial begin
    t_reset();
    t_mute();
    t_lj_single();
    t_i2s_double_div();
    t_quad();
    t_reserved();
    t_restart();
    t_capture();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(10 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule